// File: doc/BRIEF.md
# Character Display RAM Access Unit

This block is the data port of a character display controller. It moves bytes between an 8-bit host bus and two internal memories. The first is a 64-byte glyph-pattern store, called the character-generator RAM (CG). The second is an 80-byte text store, called the display-data RAM (DD). A single address counter points into whichever memory the most recent address-set instruction selected.

An entry-mode setting controls two things after each access:

- whether the counter steps up or down;
- whether a write also asks the display to scroll.

Host reads are served from a read latch rather than straight from memory. The latch is reloaded by address-set, cursor-shift and read operations, but not by writes. As a result, a read that follows a write directly returns the byte the latch held before that write.

Bus accesses are strobed. Register-select, read/write and data are taken as they stood in the last clock cycle with the enable strobe high, and the access takes effect when enable falls. Decoded instructions arrive on a separate one-cycle-valid port. If both arrive in the same cycle, the instruction is acted on and the bus access is dropped.

Top module: `char_ram_port`

## Requirements
- R1: On a falling enable edge with regSel=1 and readNWrite=0, the held data byte is stored at the address counter in the currently selected memory.
- R2: busDrive is 1 exactly while enable=1, regSel=1 and readNWrite=1, and busOut then shows the read latch. At all other times busDrive is 0.
- R3: instrCode 0 selects CG and loads the counter with instrAddr modulo 64. instrCode 1 selects DD and loads it with instrAddr modulo 80. Both reload the read latch from the new location.
- R4: After a write, the counter moves by exactly one in the entry direction and wraps within the selected memory (CG 63↔0, DD 79↔0).
- R5: A write made while the entry shift flag is set raises shiftReq for exactly one cycle, with shiftLeft equal to the entry direction (1 = incrementing).
- R6: A read returns the latch, then steps the counter in the entry direction and reloads the latch from the new address. It never raises shiftReq, so consecutive reads return consecutive locations.
- R7: A write does not reload the read latch. A read issued directly after a write returns the latch value from before the write.
- R8: instrCode 3 (cursor shift) in DD mode moves the counter by one (up when instrRight=1, down otherwise) and reloads the latch. In CG mode it has no effect.
- R9: instrCode 2 (entry mode) sets the direction (instrIncr=1 means up) and the shift flag (instrShift).
- R10: An enable strobe with regSel=0 changes neither the counter nor any memory.
- R11: After reset, DD is selected, the counter is 0, the direction is up, shifting is off, shiftReq is 0 and the read latch is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | 1 = data access |
| readNWrite | input | 1 | 1 = read, 0 = write |
| enable | input | 1 | Bus strobe; the access acts on its falling edge |
| busIn | input | 8 | Write data |
| busOut | output | 8 | Read data (read latch) |
| busDrive | output | 1 | busOut is valid and should be driven |
| instrValid | input | 1 | Decoded instruction present this cycle |
| instrCode | input | 2 | 0 CG address set, 1 DD address set, 2 entry mode, 3 cursor shift |
| instrAddr | input | 7 | Address for the address-set instructions |
| instrIncr | input | 1 | Entry mode: count up |
| instrShift | input | 1 | Entry mode: scroll on write |
| instrRight | input | 1 | Cursor shift: move up |
| addrCount | output | 7 | Address counter |
| ddSelected | output | 1 | 1 = DD is the target memory |
| shiftReq | output | 1 | One-cycle display scroll request |
| shiftLeft | output | 1 | Scroll direction for shiftReq |

## Verification
The hardest state to reach is the one where the read latch and the memory disagree. Getting there takes a write to the very location the latch was just filled from, followed by a read with no address set in between. The stimulus loads an address, overwrites that byte and reads at once to expect the old value. It then re-sets the address and reads the new one. Counter wrap is reached by setting the last entry of each memory and writing past it. For DD the set value is also given above 80, to exercise the modulo load.

// File: rtl/char_ram_pkg.sv
package char_ram_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    INSTR_SET_CG = 2'd0,
    INSTR_SET_DD = 2'd1,
    INSTR_ENTRY  = 2'd2,
    INSTR_CURSOR = 2'd3
  } instr_e;

  typedef struct packed {
    logic              loadAddr;
    logic              stepAddr;
    logic              writeMem;
    logic              refill;
    logic              tgtDd;
    logic              dirUp;
    logic [ADDR_W-1:0] newAddr;
  } acStrobe_t;
endpackage

// File: rtl/char_ram_bank.sv
module char_ram_bank #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (int'(wrAddr) < DEPTH)) mem[wrAddr] <= wrData;
  end

  generate
    if (DEPTH == (1 << AW)) begin : g_full
      assign rdData = mem[rdAddr];
    end else begin : g_part
      assign rdData = (int'(rdAddr) < DEPTH) ? mem[rdAddr] : '0;
    end
  endgenerate
endmodule

// File: rtl/char_ram_ctrl.sv
module char_ram_ctrl
  import char_ram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              readNWrite,
  input  logic              enable,
  input  logic              instrValid,
  input  logic [1:0]        instrCode,
  input  logic [ADDR_W-1:0] instrAddr,
  input  logic              instrIncr,
  input  logic              instrShift,
  input  logic              instrRight,
  output acStrobe_t         strobe,
  output logic              ddSel,
  output logic              shiftReq,
  output logic              shiftLeft
);
  logic   enPrev, heldRs, heldRw;
  logic   dirInc, shiftEn;
  logic   busFall;
  instr_e code;

  assign code      = instr_e'(instrCode);
  assign busFall   = enPrev & ~enable;
  assign shiftLeft = dirInc;

  always_comb begin
    strobe         = '0;
    strobe.tgtDd   = ddSel;
    strobe.dirUp   = dirInc;
    strobe.newAddr = instrAddr;
    if (instrValid) begin
      unique case (code)
        INSTR_SET_CG: begin
          strobe.loadAddr = 1'b1;
          strobe.refill   = 1'b1;
          strobe.tgtDd    = 1'b0;
        end
        INSTR_SET_DD: begin
          strobe.loadAddr = 1'b1;
          strobe.refill   = 1'b1;
          strobe.tgtDd    = 1'b1;
        end
        INSTR_ENTRY: begin
        end
        INSTR_CURSOR: begin
          if (ddSel) begin
            strobe.stepAddr = 1'b1;
            strobe.refill   = 1'b1;
            strobe.dirUp    = instrRight;
          end
        end
      endcase
    end else if (busFall && heldRs) begin
      strobe.stepAddr = 1'b1;
      if (heldRw) strobe.refill   = 1'b1;
      else        strobe.writeMem = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enPrev   <= 1'b0;
      heldRs   <= 1'b0;
      heldRw   <= 1'b0;
      ddSel    <= 1'b1;
      dirInc   <= 1'b1;
      shiftEn  <= 1'b0;
      shiftReq <= 1'b0;
    end else begin
      enPrev   <= enable;
      shiftReq <= strobe.writeMem & shiftEn;
      if (enable) begin
        heldRs <= regSel;
        heldRw <= readNWrite;
      end
      if (instrValid) begin
        unique case (code)
          INSTR_SET_CG: ddSel <= 1'b0;
          INSTR_SET_DD: ddSel <= 1'b1;
          INSTR_ENTRY: begin
            dirInc  <= instrIncr;
            shiftEn <= instrShift;
          end
          INSTR_CURSOR: begin
          end
        endcase
      end
    end
  end

  // R6: a read never produces a scroll request
  p_read_no_shift_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busFall && heldRs && heldRw && !instrValid) |=> !shiftReq);

  // R5: scroll request lasts one cycle
  p_shift_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    shiftReq |=> !shiftReq);
endmodule

// File: rtl/char_ram_dpath.sv
module char_ram_dpath
  import char_ram_pkg::*;
#(
  parameter int CG_DEPTH = 64,
  parameter int DD_DEPTH = 80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DATA_W-1:0] busIn,
  input  acStrobe_t         strobe,
  input  logic              ddSelQ,
  output logic [ADDR_W-1:0] acValue,
  output logic [DATA_W-1:0] latchValue
);
  localparam int CG_AW = $clog2(CG_DEPTH);
  localparam int DD_AW = $clog2(DD_DEPTH);

  logic [ADDR_W-1:0] nextAc;
  logic [DATA_W-1:0] heldData, cgRd, ddRd;
  logic              cgWe, ddWe;
  int                depthSel;

  function automatic logic [ADDR_W-1:0] stepWrap(input logic [ADDR_W-1:0] cur,
                                                 input logic up, input int depth);
    int c;
    int n;
    c = int'(cur);
    if (up) n = (c >= depth - 1) ? 0 : c + 1;
    else    n = (c == 0) ? depth - 1 : c - 1;
    return ADDR_W'(n);
  endfunction

  assign depthSel = strobe.tgtDd ? DD_DEPTH : CG_DEPTH;

  always_comb begin
    if (strobe.loadAddr)      nextAc = ADDR_W'(int'(strobe.newAddr) % depthSel);
    else if (strobe.stepAddr) nextAc = stepWrap(acValue, strobe.dirUp, depthSel);
    else                      nextAc = acValue;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acValue    <= '0;
      latchValue <= '0;
      heldData   <= '0;
    end else begin
      acValue <= nextAc;
      if (enable)        heldData   <= busIn;
      if (strobe.refill) latchValue <= strobe.tgtDd ? ddRd : cgRd;
    end
  end

  assign cgWe = strobe.writeMem & ~strobe.tgtDd;
  assign ddWe = strobe.writeMem &  strobe.tgtDd;

  char_ram_bank #(.DEPTH(CG_DEPTH), .AW(CG_AW), .DW(DATA_W)) u_cgBank (
    .clk    (clk),
    .we     (cgWe),
    .wrAddr (acValue[CG_AW-1:0]),
    .wrData (heldData),
    .rdAddr (nextAc[CG_AW-1:0]),
    .rdData (cgRd)
  );

  char_ram_bank #(.DEPTH(DD_DEPTH), .AW(DD_AW), .DW(DATA_W)) u_ddBank (
    .clk    (clk),
    .we     (ddWe),
    .wrAddr (acValue[DD_AW-1:0]),
    .wrData (heldData),
    .rdAddr (nextAc[DD_AW-1:0]),
    .rdData (ddRd)
  );

  // R4: a step moves the counter by one position modulo the memory size
  p_step_by_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepAddr && !strobe.loadAddr) |=>
      (((int'(acValue) - int'($past(acValue)) + $past(depthSel)) % $past(depthSel))
        == ($past(strobe.dirUp) ? 1 : $past(depthSel) - 1)));

  // R3: the counter stays inside the selected memory
  p_addr_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    int'(acValue) < (ddSelQ ? DD_DEPTH : CG_DEPTH));

  // R7: a write leaves the read latch untouched
  p_write_keeps_latch_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeMem |=> $stable(latchValue));
endmodule

// File: rtl/char_ram_port.sv
module char_ram_port
  import char_ram_pkg::*;
#(
  parameter int CG_DEPTH = 64,
  parameter int DD_DEPTH = 80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              readNWrite,
  input  logic              enable,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busDrive,
  input  logic              instrValid,
  input  logic [1:0]        instrCode,
  input  logic [ADDR_W-1:0] instrAddr,
  input  logic              instrIncr,
  input  logic              instrShift,
  input  logic              instrRight,
  output logic [ADDR_W-1:0] addrCount,
  output logic              ddSelected,
  output logic              shiftReq,
  output logic              shiftLeft
);
  acStrobe_t         strobe;
  logic              ddSel;
  logic [DATA_W-1:0] latchValue;

  char_ram_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regSel     (regSel),
    .readNWrite (readNWrite),
    .enable     (enable),
    .instrValid (instrValid),
    .instrCode  (instrCode),
    .instrAddr  (instrAddr),
    .instrIncr  (instrIncr),
    .instrShift (instrShift),
    .instrRight (instrRight),
    .strobe     (strobe),
    .ddSel      (ddSel),
    .shiftReq   (shiftReq),
    .shiftLeft  (shiftLeft)
  );

  char_ram_dpath #(.CG_DEPTH(CG_DEPTH), .DD_DEPTH(DD_DEPTH)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .busIn      (busIn),
    .strobe     (strobe),
    .ddSelQ     (ddSel),
    .acValue    (addrCount),
    .latchValue (latchValue)
  );

  assign busDrive   = enable & regSel & readNWrite;
  assign busOut     = busDrive ? latchValue : '0;
  assign ddSelected = ddSel;
endmodule

// File: tb/test_char_ram_port.sv
module test_char_ram_port;
  logic       clk = 1'b0;
  logic       rstN, regSel, readNWrite, enable;
  logic [7:0] busIn, busOut;
  logic       busDrive, instrValid, instrIncr, instrShift, instrRight;
  logic [1:0] instrCode;
  logic [6:0] instrAddr, addrCount;
  logic       ddSelected, shiftReq, shiftLeft;
  int         tests = 0;
  int         fails = 0;
  bit         finished = 0;

  always #5 clk = ~clk;

  char_ram_port i_char_ram_port (
    .clk(clk), .rstN(rstN), .regSel(regSel), .readNWrite(readNWrite),
    .enable(enable), .busIn(busIn), .busOut(busOut), .busDrive(busDrive),
    .instrValid(instrValid), .instrCode(instrCode), .instrAddr(instrAddr),
    .instrIncr(instrIncr), .instrShift(instrShift), .instrRight(instrRight),
    .addrCount(addrCount), .ddSelected(ddSelected), .shiftReq(shiftReq),
    .shiftLeft(shiftLeft)
  );

  // op: 0 instruction, 1 bus write, 2 bus read; flg = {incr, shift, right}
  typedef struct packed {
    logic [1:0] op;
    logic [1:0] code;
    logic [7:0] arg;
    logic [2:0] flg;
    logic [6:0] expAc;
    logic       expDd;
    logic [7:0] expRd;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd1, 8'd10,  3'b000, 7'd10, 1'b1, 8'h00}, // R3 set DD 10
    '{2'd1, 2'd0, 8'hA1,  3'b000, 7'd11, 1'b1, 8'h00}, // R4 write up
    '{2'd1, 2'd0, 8'hB2,  3'b000, 7'd12, 1'b1, 8'h00},
    '{2'd0, 2'd1, 8'd10,  3'b000, 7'd10, 1'b1, 8'h00},
    '{2'd2, 2'd0, 8'h00,  3'b000, 7'd11, 1'b1, 8'hA1}, // R6 consecutive reads
    '{2'd2, 2'd0, 8'h00,  3'b000, 7'd12, 1'b1, 8'hB2},
    '{2'd0, 2'd2, 8'h00,  3'b000, 7'd12, 1'b1, 8'h00}, // R9 decrement
    '{2'd0, 2'd1, 8'd11,  3'b000, 7'd11, 1'b1, 8'h00},
    '{2'd2, 2'd0, 8'h00,  3'b000, 7'd10, 1'b1, 8'hB2},
    '{2'd2, 2'd0, 8'h00,  3'b000, 7'd9,  1'b1, 8'hA1},
    '{2'd0, 2'd2, 8'h00,  3'b100, 7'd9,  1'b1, 8'h00}, // R9 increment
    '{2'd0, 2'd0, 8'd63,  3'b000, 7'd63, 1'b0, 8'h00}, // R3 set CG 63
    '{2'd1, 2'd0, 8'h3C,  3'b000, 7'd0,  1'b0, 8'h00}, // R4 CG wrap
    '{2'd1, 2'd0, 8'h55,  3'b000, 7'd1,  1'b0, 8'h00},
    '{2'd0, 2'd0, 8'd63,  3'b000, 7'd63, 1'b0, 8'h00},
    '{2'd2, 2'd0, 8'h00,  3'b000, 7'd0,  1'b0, 8'h3C},
    '{2'd2, 2'd0, 8'h00,  3'b000, 7'd1,  1'b0, 8'h55},
    '{2'd0, 2'd1, 8'd79,  3'b000, 7'd79, 1'b1, 8'h00},
    '{2'd1, 2'd0, 8'h79,  3'b000, 7'd0,  1'b1, 8'h00}, // R4 DD wrap
    '{2'd0, 2'd1, 8'd83,  3'b000, 7'd3,  1'b1, 8'h00}, // R3 modulo 80
    '{2'd0, 2'd1, 8'd79,  3'b000, 7'd79, 1'b1, 8'h00},
    '{2'd2, 2'd0, 8'h00,  3'b000, 7'd0,  1'b1, 8'h79}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic instr(input logic [1:0] code, input logic [6:0] addr, input logic [2:0] flg);
    @(negedge clk);
    instrValid = 1'b1; instrCode = code; instrAddr = addr;
    {instrIncr, instrShift, instrRight} = flg;
    @(negedge clk);
    instrValid = 1'b0;
  endtask

  task automatic busOp(input logic rs, input logic rw, input logic [7:0] d,
                       output logic [7:0] rd, output logic drv);
    @(negedge clk);
    regSel = rs; readNWrite = rw; busIn = d; enable = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd = busOut; drv = busDrive;
    enable = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic       drv;
    rstN = 1'b0; regSel = 1'b0; readNWrite = 1'b0; enable = 1'b0; busIn = '0;
    instrValid = 1'b0; instrCode = '0; instrAddr = '0;
    instrIncr = 1'b0; instrShift = 1'b0; instrRight = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 counter", addrCount, 0);
    check("R11 ddSelected", ddSelected, 1);
    check("R11 shiftReq", shiftReq, 0);
    check("R2 idle busDrive", busDrive, 0);
    busOp(1'b1, 1'b1, 8'h00, rd, drv);
    check("R11 latch cleared", rd, 8'h00);
    check("R2 read drive", drv, 1);
    check("R11 direction up", addrCount, 1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      if (v.op == 2'd0) begin
        instr(v.code, v.arg[6:0], v.flg);
        check("R3 R9 table counter", addrCount, v.expAc);
        check("R3 table select", ddSelected, v.expDd);
      end else if (v.op == 2'd1) begin
        busOp(1'b1, 1'b0, v.arg, rd, drv);
        check("R2 write no drive", drv, 0);
        check("R4 table counter", addrCount, v.expAc);
      end else begin
        busOp(1'b1, 1'b1, 8'h00, rd, drv);
        check("R6 table read data", rd, v.expRd);
        check("R6 table counter", addrCount, v.expAc);
      end
    end

    // R7 stale read after write
    instr(2'd1, 7'd10, 3'b000);
    busOp(1'b1, 1'b0, 8'hEE, rd, drv);
    busOp(1'b1, 1'b1, 8'h00, rd, drv);
    check("R7 stale read", rd, 8'hA1);
    check("R7 counter", addrCount, 12);
    instr(2'd1, 7'd10, 3'b000);
    busOp(1'b1, 1'b1, 8'h00, rd, drv);
    check("R1 written byte", rd, 8'hEE);

    // R8 cursor shift
    instr(2'd1, 7'd40, 3'b000);
    busOp(1'b1, 1'b0, 8'h40, rd, drv);
    busOp(1'b1, 1'b0, 8'h41, rd, drv);
    instr(2'd3, 7'd0, 3'b000);
    check("R8 cursor left", addrCount, 41);
    busOp(1'b1, 1'b1, 8'h00, rd, drv);
    check("R8 refill after cursor", rd, 8'h41);
    instr(2'd3, 7'd0, 3'b001);
    check("R8 cursor right", addrCount, 43);
    instr(2'd0, 7'd5, 3'b000);
    instr(2'd3, 7'd0, 3'b001);
    check("R8 cursor ignored in CG", addrCount, 5);
    check("R8 CG still selected", ddSelected, 0);

    // R10 strobe with regSel low
    busOp(1'b1, 1'b0, 8'h12, rd, drv);
    instr(2'd0, 7'd5, 3'b000);
    busOp(1'b0, 1'b0, 8'h99, rd, drv);
    check("R10 counter unchanged", addrCount, 5);
    instr(2'd0, 7'd5, 3'b000);
    busOp(1'b1, 1'b1, 8'h00, rd, drv);
    check("R10 memory unchanged", rd, 8'h12);

    // R5 / R9 scroll requests
    instr(2'd2, 7'd0, 3'b110);
    instr(2'd1, 7'd0, 3'b000);
    busOp(1'b1, 1'b0, 8'h11, rd, drv);
    check("R5 shiftReq on write", shiftReq, 1);
    check("R5 shiftLeft up", shiftLeft, 1);
    @(negedge clk);
    check("R5 single pulse", shiftReq, 0);
    busOp(1'b1, 1'b1, 8'h00, rd, drv);
    check("R6 no shift on read", shiftReq, 0);
    check("R6 counter after read", addrCount, 2);
    instr(2'd2, 7'd0, 3'b010);
    busOp(1'b1, 1'b0, 8'h22, rd, drv);
    check("R5 shiftReq down", shiftReq, 1);
    check("R9 shiftLeft down", shiftLeft, 0);
    check("R9 decrement", addrCount, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule